// File: doc/BRIEF.md
# High-Word Signed Multiply-Accumulate Unit

This datapath unit takes a signed multiplicand, a signed multiplier and a signed addend, all of the same width. It forms the full double-width product and adds the addend shifted up by one word, so the addend lands only in the upper half of the sum. When rounding is selected it also adds one half of a low-word unit. Only the upper word of that sum is returned. An accumulate-enable input selects the multiply-only form, in which the addend is treated as zero and the rounding choice still applies.

Operations enter and leave through a valid/ready handshake. The unit is a two-stage pipeline. The first stage registers the product plus the aligned addend. The second stage adds the rounding bias, takes the upper word and registers the result. The unit accepts one operation per cycle while the consumer keeps `out_ready` high. When the consumer stalls, the whole pipeline freezes and input is refused.

Top module: `hiword_mac`

## Requirements
- R1: Multiplicand and multiplier are both read as two's-complement values of `DATA_W` bits, and the full signed product of width 2·`DATA_W` is formed.
- R2: With `in_acc_en`=1, the sign-extended addend multiplied by 2^`DATA_W` is added to the product, so the addend affects only sum bits [2·`DATA_W`-1:`DATA_W`].
- R3: With `in_acc_en`=0, the value on `in_addend` has no effect on `out_data`; the result equals the one for an addend of zero.
- R4: With `in_round`=1, the constant 2^(`DATA_W`-1) is added to the sum before extraction, and any carry it produces propagates into bit `DATA_W` and above.
- R5: With `in_round`=0, the lower `DATA_W` bits of the sum are dropped without rounding (truncation).
- R6: `out_data` is bits [2·`DATA_W`-1:`DATA_W`] of the final sum, taken modulo 2^(2·`DATA_W`). Overflow wraps silently and is never saturated.
- R7: An operation accepted at clock edge k (`in_valid` and `in_ready` both high) appears with `out_valid` high after edge k+1, provided `out_ready` is high at edge k+1.
- R8: While `out_ready` stays high, `in_ready` stays high and one operation is accepted and one delivered per cycle, in order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` stay unchanged on the next cycle.
- R10: A synchronous active-high `rst` clears both pipeline valid stages. After it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes the offered operation this cycle |
| in_mcand | input | DATA_W | Signed multiplicand |
| in_mplier | input | DATA_W | Signed multiplier |
| in_addend | input | DATA_W | Signed addend, aligned to the upper word |
| in_acc_en | input | 1 | 1: add the addend; 0: multiply only |
| in_round | input | 1 | 1: round to nearest by bias; 0: truncate |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | DATA_W | Upper word of the final sum |

## Verification
The bench builds two copies of the unit. One uses the default `DATA_W`=32 and is driven with chosen corner operands: the most negative value squared, minus one squared, low words that sit exactly on the rounding boundary, and pseudo-random values. The other uses `DATA_W`=6, where every pair of multiplicand and multiplier can be applied. This small copy sees every operand pair, and addend, accumulate and round settings that vary across the sweep. That reaches every sign combination, every carry out of the low word and every wrap of the upper word. Both copies also run with a pseudo-random `out_ready` to exercise the stall, hold and ordering behaviour.

// File: rtl/hiword_mac_pkg.sv
package hiword_mac_pkg;

  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_NEAREST = 1'b1
  } rnd_mode_e;

  // Half of one low-word unit, at bit (w-1) of the double-width sum.
  function automatic logic [63:0] half_lsb_bias(input int unsigned w);
    return 64'd1 << (w - 1);
  endfunction

endpackage

// File: rtl/hiword_mac_ctrl.sv
module hiword_mac_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic advance,
  output logic in_ready,
  output logic out_valid
);
  logic s1_valid_q;
  logic s2_valid_q;
  logic stall;
  logic accept;

  assign stall     = s2_valid_q && !out_ready;
  assign advance   = !stall;
  assign in_ready  = advance;
  assign out_valid = s2_valid_q;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else if (advance) begin
      s1_valid_q <= in_valid;
      s2_valid_q <= s1_valid_q;
    end
  end

  // R7: an accepted operation is presented after the next edge that advances
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    accept ##1 out_ready |=> out_valid);

  // R8: an empty output stage never refuses input
  p_idle_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R10: reset empties the output stage
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/hiword_mac_mul.sv
module hiword_mac_mul #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [DATA_W-1:0]     mcand,
  input  logic [DATA_W-1:0]     mplier,
  input  logic [DATA_W-1:0]     addend,
  input  logic                  acc_en,
  input  logic                  round_in,
  output logic [2*DATA_W-1:0]   sum_q,
  output logic                  round_q
);
  localparam int unsigned SUM_W = 2 * DATA_W;

  // Full signed product: sign-extend both to SUM_W, keep SUM_W bits.
  function automatic logic [SUM_W-1:0] signed_product(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    logic signed [SUM_W-1:0] xs;
    logic signed [SUM_W-1:0] ys;
    xs = {{DATA_W{x[DATA_W-1]}}, x};
    ys = {{DATA_W{y[DATA_W-1]}}, y};
    return SUM_W'(xs * ys);
  endfunction

  // Addend placed in the upper word; zero in multiply-only form.
  function automatic logic [SUM_W-1:0] aligned_addend(
    input logic [DATA_W-1:0] c, input logic use_it);
    return use_it ? {c, {DATA_W{1'b0}}} : '0;
  endfunction

  logic [SUM_W-1:0] product;
  logic [SUM_W-1:0] upper_term;
  logic [SUM_W-1:0] sum_d;

  assign product    = signed_product(mcand, mplier);
  assign upper_term = aligned_addend(addend, acc_en);
  assign sum_d      = product + upper_term;

  always_ff @(posedge clk) begin
    if (en) begin
      sum_q   <= sum_d;
      round_q <= round_in;
    end
  end

  // R2/R3: the addend term never touches the low word
  p_low_word_clean_r2: assert property (@(posedge clk)
    upper_term[DATA_W-1:0] == '0);

endmodule

// File: rtl/hiword_mac_rnd.sv
module hiword_mac_rnd #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [2*DATA_W-1:0]   sum_in,
  input  logic                  round_in,
  output logic [DATA_W-1:0]     result_q
);
  import hiword_mac_pkg::*;

  localparam int unsigned SUM_W = 2 * DATA_W;
  localparam logic [63:0] BIAS64 = half_lsb_bias(DATA_W);
  localparam logic [SUM_W-1:0] BIAS = BIAS64[SUM_W-1:0];

  function automatic logic [DATA_W-1:0] upper_word(
    input logic [SUM_W-1:0] s, input rnd_mode_e mode);
    logic [SUM_W-1:0] t;
    t = (mode == RND_NEAREST) ? s + BIAS : s;
    return t[SUM_W-1:DATA_W];
  endfunction

  rnd_mode_e mode;
  logic [DATA_W-1:0] result_d;

  assign mode     = rnd_mode_e'(round_in);
  assign result_d = upper_word(sum_in, mode);

  always_ff @(posedge clk) begin
    if (en) result_q <= result_d;
  end

  // R9: a frozen stage keeps its result
  p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result_q));

endmodule

// File: rtl/hiword_mac.sv
module hiword_mac #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_mcand,
  input  logic [DATA_W-1:0] in_mplier,
  input  logic [DATA_W-1:0] in_addend,
  input  logic              in_acc_en,
  input  logic              in_round,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned SUM_W = 2 * DATA_W;

  logic             advance;
  logic [SUM_W-1:0] s1_sum;
  logic             s1_round;

  hiword_mac_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .advance   (advance),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  hiword_mac_mul #(.DATA_W(DATA_W)) u_mul (
    .clk      (clk),
    .en       (advance),
    .mcand    (in_mcand),
    .mplier   (in_mplier),
    .addend   (in_addend),
    .acc_en   (in_acc_en),
    .round_in (in_round),
    .sum_q    (s1_sum),
    .round_q  (s1_round)
  );

  hiword_mac_rnd #(.DATA_W(DATA_W)) u_rnd (
    .clk      (clk),
    .rst      (rst),
    .en       (advance),
    .sum_in   (s1_sum),
    .round_in (s1_round),
    .result_q (out_data)
  );

  // R9: a stalled result stays presented and unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: input is refused while the output is stalled
  p_stall_refuse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/hiword_mac_bench.sv
module hiword_mac_bench;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;
  logic mon_en = 1'b0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // big instance
  logic        b_ivalid = 0, b_irdy, b_acc = 0, b_rnd = 0, b_ovalid, b_ordy;
  logic [31:0] b_a = 0, b_b = 0, b_c = 0, b_odata;
  // small instance
  logic          s_ivalid = 0, s_irdy, s_acc = 0, s_rnd = 0, s_ovalid, s_ordy;
  logic [SW-1:0] s_a = 0, s_b = 0, s_c = 0, s_odata;

  logic [31:0] b_q[$];
  string       b_t[$];
  logic [31:0] s_q[$];
  string       s_t[$];

  hiword_mac u_hiword_mac (
    .clk(clk), .rst(rst), .in_valid(b_ivalid), .in_ready(b_irdy),
    .in_mcand(b_a), .in_mplier(b_b), .in_addend(b_c), .in_acc_en(b_acc),
    .in_round(b_rnd), .out_valid(b_ovalid), .out_ready(b_ordy), .out_data(b_odata));

  hiword_mac #(.DATA_W(SW)) u_hiword_mac_small (
    .clk(clk), .rst(rst), .in_valid(s_ivalid), .in_ready(s_irdy),
    .in_mcand(s_a), .in_mplier(s_b), .in_addend(s_c), .in_acc_en(s_acc),
    .in_round(s_rnd), .out_valid(s_ovalid), .out_ready(s_ordy), .out_data(s_odata));

  function automatic longint sx(input logic [31:0] v, input int w);
    longint m = (longint'(1) <<< w) - 1;
    longint x = longint'(v) & m;
    if (((x >>> (w - 1)) & 1) != 0) x = x - (longint'(1) <<< w);
    return x;
  endfunction

  // Arithmetic model: hi word of a*b + (c << w) + bias, modulo 2^(2w).
  function automatic logic [31:0] model(input logic [31:0] a, b, c,
                                        input logic acc, rnd, input int w);
    longint s = sx(a, w) * sx(b, w);
    longint m = (longint'(1) <<< w) - 1;
    if (acc) s = s + (sx(c, w) <<< w);
    if (rnd) s = s + (longint'(1) <<< (w - 1));
    return 32'((s >>> w) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      1:       begin b_ordy <= lfsr[0] | lfsr[3]; s_ordy <= lfsr[1] | lfsr[5]; end
      2:       begin b_ordy <= 1'b0; s_ordy <= 1'b0; end
      default: begin b_ordy <= 1'b1; s_ordy <= 1'b1; end
    endcase
  end

  logic        b_hold = 0, s_hold = 0;
  logic [31:0] b_hval = 0, s_hval = 0;

  always @(negedge clk) begin
    #3;
    if (mon_en) begin
      if (b_hold) begin
        chk("R9 big hold valid", 32'(b_ovalid), 32'd1);
        chk("R9 big hold data", b_odata, b_hval);
      end
      if (b_ovalid && !b_ordy) chk("R9 big in_ready low", 32'(b_irdy), 32'd0);
      if (b_ovalid && b_ordy) begin
        if (b_q.size() == 0) chk("R8 big unexpected result", 32'd1, 32'd0);
        else chk(b_t.pop_front(), b_odata, b_q.pop_front());
      end
      b_hold = b_ovalid && !b_ordy; b_hval = b_odata;
      if (s_hold) begin
        chk("R9 small hold valid", 32'(s_ovalid), 32'd1);
        chk("R9 small hold data", 32'(s_odata), s_hval);
      end
      if (s_ovalid && !s_ordy) chk("R9 small in_ready low", 32'(s_irdy), 32'd0);
      if (s_ovalid && s_ordy) begin
        if (s_q.size() == 0) chk("R8 small unexpected result", 32'd1, 32'd0);
        else chk(s_t.pop_front(), 32'(s_odata), s_q.pop_front());
      end
      s_hold = s_ovalid && !s_ordy; s_hval = 32'(s_odata);
    end else begin
      b_hold = 0; s_hold = 0;
    end
  end

  task automatic send_big(input logic [31:0] a, b, c, input logic acc, rnd, input string tag);
    logic got = 0;
    while (!got) begin
      @(negedge clk); #1;
      b_a = a; b_b = b; b_c = c; b_acc = acc; b_rnd = rnd; b_ivalid = 1;
      #1;
      if (b_irdy) begin
        got = 1;
        b_q.push_back(model(a, b, c, acc, rnd, 32));
        b_t.push_back(tag);
      end
    end
  endtask

  task automatic send_small(input logic [31:0] a, b, c, input logic acc, rnd, input string tag);
    logic got = 0;
    while (!got) begin
      @(negedge clk); #1;
      s_a = SW'(a); s_b = SW'(b); s_c = SW'(c); s_acc = acc; s_rnd = rnd; s_ivalid = 1;
      #1;
      if (s_irdy) begin
        got = 1;
        s_q.push_back(model(a, b, c, acc, rnd, SW));
        s_t.push_back(tag);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1; b_ivalid = 0; s_ivalid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep_small(input string tag);
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        send_small(32'(a), 32'(b), 32'((a * 5 + b * 3 + 7) & 63),
                   logic'((a ^ b) & 1), logic'(((a >> 2) ^ (b >> 1)) & 1), tag);
  endtask

  initial begin
    logic [31:0] r1, r2, r3;
    r1 = 32'h1234_5678; r2 = 32'h9E37_79B9; r3 = 32'h0F0F_3C3C;
    repeat (3) @(negedge clk);
    #3;
    chk("R10 reset out_valid", 32'(b_ovalid), 32'd0);
    chk("R10 reset in_ready", 32'(b_irdy), 32'd1);
    rst = 0;
    mon_en = 1;

    // R7: latency on an idle pipeline
    send_big(32'd3, 32'd5, 32'd0, 1'b0, 1'b0, "R7 latency value");
    @(posedge clk); #1; b_ivalid = 0;
    @(negedge clk); #3; chk("R7 not valid after one edge", 32'(b_ovalid), 32'd0);
    @(negedge clk); #3; chk("R7 valid after two edges", 32'(b_ovalid), 32'd1);
    idle(3);

    // R1/R5/R6: corner operands, truncation
    send_big(32'h8000_0000, 32'h8000_0000, 32'd0, 1'b0, 1'b0, "R1 min*min");
    send_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0, "R5 -1*-1 trunc");
    send_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b1, "R4 -1*-1 round");
    send_big(32'h0001_0000, 32'h0000_8000, 32'd0, 1'b0, 1'b0, "R5 boundary trunc");
    send_big(32'h0001_0000, 32'h0000_8000, 32'd0, 1'b0, 1'b1, "R4 boundary carry");
    send_big(32'hFFFF_0000, 32'h0000_8000, 32'd0, 1'b0, 1'b1, "R4 negative boundary");
    send_big(32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 1'b0, 1'b0, "R1 max*min");
    send_big(32'h0000_0002, 32'h0000_0003, 32'h0000_0007, 1'b1, 1'b0, "R2 addend upper");
    send_big(32'h0000_0002, 32'h0000_0003, 32'hDEAD_BEEF, 1'b0, 1'b0, "R3 addend ignored");
    send_big(32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, "R6 wrap");
    send_big(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, "R6 wrap round");
    send_big(32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1, "R2 min addend");
    for (int i = 0; i < 400; i++) begin
      r1 = r1 ^ (r1 << 13); r1 = r1 ^ (r1 >> 17); r1 = r1 ^ (r1 << 5);
      r2 = r2 ^ (r2 << 13); r2 = r2 ^ (r2 >> 17); r2 = r2 ^ (r2 << 5);
      r3 = r3 ^ (r3 << 13); r3 = r3 ^ (r3 >> 17); r3 = r3 ^ (r3 << 5);
      send_big(r1, r2, r3, r1[0], r2[0], "R8 big random stream");
    end
    rmode = 1;
    for (int i = 0; i < 400; i++) begin
      r1 = r1 ^ (r1 << 13); r1 = r1 ^ (r1 >> 17); r1 = r1 ^ (r1 << 5);
      r2 = r2 ^ (r2 << 13); r2 = r2 ^ (r2 >> 17); r2 = r2 ^ (r2 << 5);
      send_big(r1, r2, r1 ^ r2, r2[1], r1[1], "R9 big stalled stream");
    end
    rmode = 0;
    idle(6);

    // full sweep of the small copy, free-flowing then with stalls
    sweep_small("R1 sweep small");
    idle(6);
    rmode = 1;
    sweep_small("R9 sweep small stalled");
    rmode = 0;
    idle(6);

    // R10: reset while a stalled result is presented
    rmode = 2;
    mon_en = 0;
    send_big(32'd7, 32'd9, 32'd0, 1'b0, 1'b0, "R10 flushed");
    idle(4);
    #3; chk("R9 stalled result present", 32'(b_ovalid), 32'd1);
    @(negedge clk); rst = 1;
    @(negedge clk); #3;
    chk("R10 reset clears out_valid", 32'(b_ovalid), 32'd0);
    chk("R10 reset in_ready high", 32'(b_irdy), 32'd1);
    rst = 0;
    b_q.delete(); b_t.delete(); s_q.delete(); s_t.delete();
    rmode = 0;
    idle(2);
    mon_en = 1;
    send_big(32'hFFFF_FFFE, 32'h0000_0003, 32'h0000_0001, 1'b1, 1'b1, "R8 after reset");
    idle(6);

    chk("R8 big all delivered", 32'(b_q.size()), 32'd0);
    chk("R8 small all delivered", 32'(s_q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule